// File: doc/BRIEF.md
# External Interrupt Sense and Latch Controller

This block conditions eight external interrupt request pins and one non-maskable interrupt pin before they reach a downstream interrupt distributor. Every pin is synchronised into the core clock domain. Each request pin is then classified by its own detection mode: active-low level, falling edge, rising edge, or either edge. A detected event sets a sticky request flag, and the flag drives the matching request output directly. The non-maskable pin has its own edge select and request flag, and its current level can be read back.

Software reaches the block through a single-cycle register port that is 16 bits wide. The port carries a word index, a read strobe and a write strobe. Read data is combinational from the word index. There is no valid/ready handshake, so the port never stalls and never applies back-pressure.

Flags clear by a write of 0. A clear only takes effect on a flag that software has already seen set through a read. Writing 1 leaves a flag as it is. A flag in level mode simply tracks the inverted pin, so a clear write cannot hold it low.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset all request flags and outputs are 0, every mode field is 0 (level-low), and the non-maskable edge select is 0 (falling). With pins held high, word 0 reads 0x8000 and words 1 and 2 read 0x0000.
- R2: Word 1 (byte offset 2) is the mode register. Field n sits at bits [2n+1:2n] and holds a code: 0 level-low, 1 falling, 2 rising, 3 either edge. All 16 bits write and read back unchanged.
- R3: In falling mode (code 1), a high-to-low transition on pin n sets request bit n. The flag shows at the third rising clock edge after the pin changes, and not at the second.
- R4: In rising mode (code 2), a low-to-high transition sets the request bit.
- R5: In either-edge mode (code 3), both transitions set the request bit.
- R6: In level-low mode (code 0), request bit n follows the inverted synchronised pin with the same three-edge latency. A clear write has no lasting effect while the pin stays low.
- R7: Word 2 (byte offset 4) holds request bit n at bit n. Writing 0 to a bit clears it once it has been read as 1; writing 1 leaves it unchanged. Other bits are not affected.
- R8: A clear write to a request bit that has not been read as 1 since it was set has no effect.
- R9: When an edge event and an effective clear hit the same bit in the same cycle, the bit stays set.
- R10: Word 0 (byte offset 0) bit 8 selects the non-maskable edge (0 falling, 1 rising). Bit 1 is its request flag, which is set on the selected edge and cleared by R7 rules. The flag drives nmi_req_o.
- R11: Word 0 bit 15 reads the synchronised non-maskable pin level; writes to it are ignored.
- R12: irq_req_o equals the request bits. Unused bits of every word read as 0 and ignore writes, and word 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | 8 | Asynchronous external request pins |
| nmi_pin_i | input | 1 | Asynchronous non-maskable pin |
| reg_word_i | input | 2 | Register word index (byte offset / 2) |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, marks data as observed by software |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for reg_word_i |
| irq_req_o | output | 8 | Per-pin request flags to the distributor |
| nmi_req_o | output | 1 | Non-maskable request flag |

## Verification
The bench checks each symptom at the port where it first appears. A wrong synchroniser or previous-value register shows as a request one edge early or late: one cycle after a pin transition reaches the third edge. A wrong mode decode shows as a missing or spurious flag on irq_req_o three edges after a transition. A broken observed-before-clear state appears when the next request-word read follows a clear write: a flag that should have survived is 0, or one that should have cleared is still 1. Level-mode faults show within three edges because the flag keeps tracking the pin.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // detection mode of one request pin
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int WORD_W = 2;

  // register word indices (byte offset / 2)
  localparam logic [WORD_W-1:0] WORD_CTL   = 2'd0;
  localparam logic [WORD_W-1:0] WORD_SENSE = 2'd1;
  localparam logic [WORD_W-1:0] WORD_REQ   = 2'd2;

  // bit positions inside the control word
  localparam int CTL_LVL_BIT  = 15;
  localparam int CTL_EDGE_BIT = 8;
  localparam int CTL_FLAG_BIT = 1;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;
  logic [WIDTH-1:0] prev_q;

  // idle level of the pins is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      sync_q <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign prev_o = prev_q;

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  sense_e mode_i,
  input  logic   sync_i,
  input  logic   prev_i,
  output logic   evt_o,
  output logic   level_o
);

  logic fall;
  logic rise;

  assign fall = prev_i & ~sync_i;
  assign rise = ~prev_i & sync_i;

  always_comb begin
    evt_o   = 1'b0;
    level_o = 1'b0;
    case (mode_i)
      SENSE_LOW:  level_o = 1'b1;
      SENSE_FALL: evt_o   = fall;
      SENSE_RISE: evt_o   = rise;
      SENSE_BOTH: evt_o   = fall | rise;
      default:    evt_o   = 1'b0;
    endcase
  end

endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic follow_i,
  input  logic follow_val_i,
  input  logic seen_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;
  logic flag_d;
  logic armed_q;
  logic armed_d;
  logic clr_ok;

  // a clear counts only after software has observed the flag set
  assign clr_ok = clr_i & armed_q;

  always_comb begin
    if (follow_i) begin
      flag_d = follow_val_i;
    end else begin
      flag_d = evt_i | (flag_q & ~clr_ok);
    end
    armed_d = flag_d & (armed_q | (seen_i & flag_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_pin_i,
  input  logic                 nmi_pin_i,
  input  logic [WORD_W-1:0]    reg_word_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic [NUM_IRQ-1:0]   irq_req_o,
  output logic                 nmi_req_o
);

  localparam int SENSE_W = 2 * NUM_IRQ;
  localparam int PINS    = NUM_IRQ + 1;
  localparam int NMI_IDX = NUM_IRQ;

  logic [PINS-1:0]    pin_sync;
  logic [PINS-1:0]    pin_prev;
  logic [SENSE_W-1:0] sense_q;
  logic               nmi_edge_q;
  logic [NUM_IRQ-1:0] irq_evt;
  logic [NUM_IRQ-1:0] irq_lvl;
  logic [NUM_IRQ-1:0] irq_flag;
  logic               nmi_evt;
  logic               nmi_lvl_unused;
  logic               nmi_flag;

  logic wr_ctl, wr_sense, wr_req;
  logic rd_ctl, rd_req;

  assign wr_ctl   = reg_wr_i & (reg_word_i == WORD_CTL);
  assign wr_sense = reg_wr_i & (reg_word_i == WORD_SENSE);
  assign wr_req   = reg_wr_i & (reg_word_i == WORD_REQ);
  assign rd_ctl   = reg_rd_i & (reg_word_i == WORD_CTL);
  assign rd_req   = reg_rd_i & (reg_word_i == WORD_REQ);

  // one synchroniser bank for all request pins plus the non-maskable pin
  ext_irq_sync #(.WIDTH(PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({nmi_pin_i, irq_pin_i}),
    .sync_o  (pin_sync),
    .prev_o  (pin_prev)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q    <= '0;
      nmi_edge_q <= 1'b0;
    end else begin
      if (wr_sense) sense_q    <= reg_wdata_i[SENSE_W-1:0];
      if (wr_ctl)   nmi_edge_q <= reg_wdata_i[CTL_EDGE_BIT];
    end
  end

  // per-pin detection and latching
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_pin
    ext_irq_detect u_det (
      .mode_i  (sense_e'(sense_q[2*n +: 2])),
      .sync_i  (pin_sync[n]),
      .prev_i  (pin_prev[n]),
      .evt_o   (irq_evt[n]),
      .level_o (irq_lvl[n])
    );

    ext_irq_flag u_flag (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_i        (irq_evt[n]),
      .follow_i     (irq_lvl[n]),
      .follow_val_i (~pin_sync[n]),
      .seen_i       (rd_req),
      .clr_i        (wr_req & ~reg_wdata_i[n]),
      .flag_o       (irq_flag[n])
    );
  end

  // non-maskable pin: edge only, direction from the control word
  ext_irq_detect u_nmi_det (
    .mode_i  (nmi_edge_q ? SENSE_RISE : SENSE_FALL),
    .sync_i  (pin_sync[NMI_IDX]),
    .prev_i  (pin_prev[NMI_IDX]),
    .evt_o   (nmi_evt),
    .level_o (nmi_lvl_unused)
  );

  ext_irq_flag u_nmi_flag (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (nmi_evt),
    .follow_i     (1'b0),
    .follow_val_i (nmi_lvl_unused),
    .seen_i       (rd_ctl),
    .clr_i        (wr_ctl & ~reg_wdata_i[CTL_FLAG_BIT]),
    .flag_o       (nmi_flag)
  );

  // read mux
  always_comb begin
    reg_rdata_o = '0;
    case (reg_word_i)
      WORD_CTL: begin
        reg_rdata_o[CTL_LVL_BIT]  = pin_sync[NMI_IDX];
        reg_rdata_o[CTL_EDGE_BIT] = nmi_edge_q;
        reg_rdata_o[CTL_FLAG_BIT] = nmi_flag;
      end
      WORD_SENSE: reg_rdata_o[SENSE_W-1:0] = sense_q;
      WORD_REQ:   reg_rdata_o[NUM_IRQ-1:0] = irq_flag;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_req_o = irq_flag;
  assign nmi_req_o = nmi_flag;

endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WORD_W-1:0]    reg_word_i,
  input logic                 reg_wr_i,
  input logic [DATA_W-1:0]    reg_wdata_i,
  input logic [DATA_W-1:0]    reg_rdata_o,
  input logic [NUM_IRQ-1:0]   irq_req_o,
  input logic                 nmi_req_o,
  input logic [2*NUM_IRQ-1:0] sense_q,
  input logic [NUM_IRQ:0]     pin_sync,
  input logic [NUM_IRQ-1:0]   irq_evt,
  input logic                 nmi_evt
);

  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_chk
    // R9: a detected edge always leaves the flag set next cycle
    assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_evt[n] |=> irq_req_o[n]);

    // R6: level mode tracks the inverted synchronised pin
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_q[2*n +: 2] == 2'd0) |=> (irq_req_o[n] == !$past(pin_sync[n])));

    // R8: in edge modes a flag only drops after a clear write to its bit
    assert_no_stray_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(irq_req_o[n]) && ($past(sense_q[2*n +: 2]) != 2'd0)) |->
        $past(reg_wr_i && (reg_word_i == WORD_REQ) && !reg_wdata_i[n]));
  end

  // R12: request word mirrors the outputs, upper bits zero
  assert_req_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word_i == WORD_REQ) |->
      ((reg_rdata_o[NUM_IRQ-1:0] == irq_req_o) && ((reg_rdata_o >> NUM_IRQ) == '0)));

  // R12: unmapped word reads zero
  assert_unused_word_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word_i == 2'd3) |-> (reg_rdata_o == '0));

  // R10: non-maskable event sets its flag
  assert_nmi_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_evt |=> nmi_req_o);

  // R10: control word flag bit mirrors the output
  assert_nmi_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_word_i == WORD_CTL) |-> (reg_rdata_o[CTL_FLAG_BIT] == nmi_req_o));

endmodule

bind ext_irq_sense ext_irq_sense_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_word_i  (reg_word_i),
  .reg_wr_i    (reg_wr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .irq_req_o   (irq_req_o),
  .nmi_req_o   (nmi_req_o),
  .sense_q     (sense_q),
  .pin_sync    (pin_sync),
  .irq_evt     (irq_evt),
  .nmi_evt     (nmi_evt)
);

// File: tb/test_ext_irq_sense.sv
`timescale 1ns/1ps
module test_ext_irq_sense;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic [1:0]  word = 2'd0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_pin_i   (irq_pin),
    .nmi_pin_i   (nmi_pin),
    .reg_word_i  (word),
    .reg_wr_i    (wr),
    .reg_rd_i    (rd),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_req_o   (irq_req),
    .nmi_req_o   (nmi_req)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic reg_read(input logic [1:0] w, output logic [15:0] v);
    word = w; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] w, input logic [15:0] d);
    word = w; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic logic [7:0] exp_req(input logic [15:0] s, input logic [7:0] o, input logic [7:0] p);
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      case (s[2*n +: 2])
        2'd0: r[n] = ~p[n];
        2'd1: r[n] = o[n] & ~p[n];
        2'd2: r[n] = ~o[n] & p[n];
        default: r[n] = o[n] ^ p[n];
      endcase
    end
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [15:0] s;
    logic [7:0]  newp;
    void'($urandom(32'd20240611));
    cyc(3);
    rst_n = 1'b1;
    cyc(3);

    // R1 reset state
    chk("R1 outputs", {7'h0, nmi_req, irq_req}, 16'h0);
    reg_read(2'd0, v); chk("R1 ctl", v, 16'h8000);
    reg_read(2'd1, v); chk("R1 sense", v, 16'h0000);
    reg_read(2'd2, v); chk("R1 req", v, 16'h0000);

    // R2 mode register round trip
    reg_write(2'd1, 16'hA5C3);
    reg_read(2'd1, v); chk("R2 sense rw", v, 16'hA5C3);

    // R3 falling edge latency
    reg_write(2'd1, 16'h5555);
    irq_pin[0] = 1'b0;
    cyc(2); chk("R3 not yet", {15'h0, irq_req[0]}, 16'h0);
    cyc(1); chk("R3 set", {8'h0, irq_req}, 16'h0001);

    // R8 clear without prior read ignored
    reg_write(2'd2, 16'h0000);
    chk("R8 unarmed clear", {8'h0, irq_req}, 16'h0001);

    // R7 write 1 keeps, write 0 clears only that bit
    irq_pin[1] = 1'b0; cyc(3);
    reg_read(2'd2, v); chk("R7 two set", v, 16'h0003);
    reg_write(2'd2, 16'hFFFF);
    reg_read(2'd2, v); chk("R7 write ones", v, 16'h0003);
    reg_write(2'd2, 16'hFFFE);
    reg_read(2'd2, v); chk("R7 single clear", v, 16'h0002);

    // R4 rising
    reg_write(2'd1, 16'hAAAA);
    irq_pin[0] = 1'b1; cyc(3);
    reg_read(2'd2, v); chk("R4 rise", v, 16'h0003);
    reg_write(2'd2, 16'h0000);
    reg_read(2'd2, v); chk("R7 clear all", v, 16'h0000);

    // R5 both edges
    reg_write(2'd1, 16'hFFFF);
    irq_pin[2] = 1'b0; cyc(3);
    reg_read(2'd2, v); chk("R5 fall", v, 16'h0004);
    reg_write(2'd2, 16'hFFFB);
    irq_pin[2] = 1'b1; cyc(3);
    reg_read(2'd2, v); chk("R5 rise", v, 16'h0004);
    reg_write(2'd2, 16'h0000);

    // R9 event and clear in the same cycle
    irq_pin[4] = 1'b0; cyc(3);
    reg_read(2'd2, v); chk("R9 armed", v, 16'h0010);
    irq_pin[4] = 1'b1; cyc(2);
    reg_write(2'd2, 16'hFFEF);
    chk("R9 event wins", {15'h0, irq_req[4]}, 16'h0001);
    reg_read(2'd2, v);
    reg_write(2'd2, 16'h0000);
    reg_read(2'd2, v); chk("R9 later clear", v, 16'h0000);

    // R6 level-low
    irq_pin[1] = 1'b1; cyc(3);
    reg_write(2'd1, 16'h0000); cyc(1);
    chk("R6 idle", {8'h0, irq_req}, 16'h0000);
    irq_pin[3] = 1'b0; cyc(3);
    chk("R6 low", {8'h0, irq_req}, 16'h0008);
    reg_read(2'd2, v);
    reg_write(2'd2, 16'h0000); cyc(1);
    chk("R6 clear no effect", {8'h0, irq_req}, 16'h0008);
    irq_pin[3] = 1'b1; cyc(3);
    chk("R6 released", {8'h0, irq_req}, 16'h0000);

    // R10 / R11 non-maskable
    nmi_pin = 1'b0; cyc(3);
    chk("R10 fall set", {15'h0, nmi_req}, 16'h0001);
    reg_read(2'd0, v); chk("R11 level low", v, 16'h0002);
    reg_write(2'd0, 16'h0000);
    reg_read(2'd0, v); chk("R10 clear", v, 16'h0000);
    reg_write(2'd0, 16'h0100);
    nmi_pin = 1'b1; cyc(3);
    reg_read(2'd0, v); chk("R10 rise", v, 16'h8102);
    // R12 unused bits and word
    reg_write(2'd0, 16'h7EFF);
    reg_read(2'd0, v); chk("R12 ctl unused", v, 16'h8002);
    reg_write(2'd3, 16'hFFFF);
    reg_read(2'd3, v); chk("R12 word3", v, 16'h0000);
    reg_read(2'd1, v); chk("R12 sense untouched", v, 16'h0000);

    // random rounds: R3 R4 R5 R6 R12
    for (int k = 0; k < 40; k++) begin
      s = 16'($urandom);
      reg_write(2'd1, s); cyc(4);
      reg_read(2'd2, v);
      reg_write(2'd2, 16'h0000); cyc(1);
      newp = 8'($urandom);
      begin
        logic [7:0] oldp;
        oldp = irq_pin;
        irq_pin = newp; cyc(4);
        reg_read(2'd2, v);
        chk("R3 R4 R5 R6 random", v, {8'h0, exp_req(s, oldp, newp)});
        chk("R12 out match", {8'h0, irq_req}, {8'h0, exp_req(s, oldp, newp)});
      end
    end

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule